// File: doc/BRIEF.md
# Sync-Gated Receive Bit Queue with Serial Readout

This block sits behind a radio demodulator. It takes the recovered data bits, each marked by a one-cycle strobe, and watches them for a synchronisation word that software programs. The word can be 8 or 16 bits long. Until the word has been seen while the front end flags its data as valid, every bit is thrown away. This keeps noise out of the buffer and saves the host from reading garbage. Once the word has been seen, every following bit goes into a 16-entry bit queue.

A host drains the queue through a read-only SPI slave port. While chip select is low, each bit is presented on the data output before a rising SCK edge. The falling edge that follows removes that bit from the queue. The oldest bit comes out first, so a 16-clock transfer returns the stream with its first bit as the MSB. The block also reports the fill level, raises an interrupt when the level reaches a programmable threshold, and holds a sticky overflow flag. Dropping the enable flushes the queue and restarts the search for the word.

Top module: `syncq_rx`

## Requirements
- R1: After reset, `fill_level` is 0 and `irq`, `ovf` and `spi_sdo` are all 0.
- R2: While `cfg_en` is 0, no received bit is stored, whatever the stream carries.
- R3: No bit is stored until a strobed bit completes a match of the sync word while `rx_qual` is 1 on that same bit. The sync word's own bits are never stored.
- R4: Each strobed bit shifts into bit 0 of the search history, so the word is sent with its MSB first. With `cfg_len_long`=0, the history's low 8 bits are compared with `cfg_pattern[7:0]`. With `cfg_len_long`=1, all 16 bits are compared with `cfg_pattern`. A match also needs at least 8 (or 16) strobed bits since the search was armed, counting the completing bit.
- R5: After a match, every strobed bit is stored, whatever `rx_qual` is, until `cfg_en` goes to 0. One cycle after `cfg_en` is 0, the queue is empty, `ovf` is 0 and the search is re-armed.
- R6: The queue holds 16 bits. A bit that arrives while the queue is full, with no removal in that cycle, is dropped and sets `ovf`. `ovf` stays set until the search is re-armed.
- R7: `irq` is 1 exactly when `fill_level` is at least the effective threshold. The effective threshold is `cfg_thresh` clamped to the range 1..16, so 0 acts as 1 and any value above 16 acts as 16.
- R8: In a transfer, the bit shown on `spi_sdo` before each rising SCK edge is the oldest stored bit. It is removed on the next falling SCK edge. When the queue is empty, `spi_sdo` is 0 and nothing is removed.
- R9: While `spi_csn` is 1, `spi_sdo` is 0 and the transfer state is cleared. At most 16 bits are removed per chip-select-low period. A transfer cut short leaves the rest of the bits for the next transfer.
- R10: `fill_level` equals the number of stored bits: it rises by one for each stored bit and falls by one for each removed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Demodulated data bit |
| rx_strobe | input | 1 | One-cycle marker: `rx_bit` is a new bit |
| rx_qual | input | 1 | Front end reports valid data |
| cfg_en | input | 1 | Queue enable; a low level flushes the queue and re-arms the search |
| cfg_pattern | input | 16 | Sync word |
| cfg_len_long | input | 1 | 0: 8-bit word, 1: 16-bit word |
| cfg_thresh | input | 5 | Interrupt fill threshold |
| spi_sck | input | 1 | SPI clock, sampled by `clk` |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sdo | output | 1 | SPI data out |
| fill_level | output | 5 | Number of stored bits, 0..16 |
| irq | output | 1 | Fill threshold reached |
| ovf | output | 1 | Sticky overflow flag |

## Verification
On every cycle, the assertions check the following:
- the level never exceeds 16 and changes by at most one per cycle;
- the level cannot grow while the search is still hunting;
- capture can only start on a qualified strobed bit;
- a low enable flushes the queue and clears the flags;
- the overflow flag stays set;
- `irq` is consistent at an empty and at a full queue;
- the data output is silent while chip select is inactive.

Only the bench scenarios can show that the right bits come out in the right order after the word is found. The same holds for the 8-bit and 16-bit comparison windows, for a transfer cut short or run past 16 clocks, and for the threshold clamp. The bench covers these with its own model of the search and the queue.

// File: rtl/syncq_pkg.sv
package syncq_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_CAPT = 1'b1
  } hunt_state_e;

  // Effective interrupt threshold: forced into 1..depth.
  function automatic int clamp_thresh(input int t, input int depth);
    if (t < 1)     return 1;
    if (t > depth) return depth;
    return t;
  endfunction

  // Circular pointer advance for a ring of n slots.
  function automatic int wrap_inc(input int p, input int n);
    return (p >= n - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/syncq_hunter.sv
module syncq_hunter
  import syncq_pkg::*;
#(
  parameter int PAT_W   = 16,
  parameter int SHORT_W = 8,
  localparam int CW     = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rx_strobe,
  input  logic             rx_bit,
  input  logic             rx_qual,
  input  logic [PAT_W-1:0] pattern,
  input  logic             len_long,
  output logic             capturing,
  output logic             push
);

  hunt_state_e      state;
  logic [PAT_W-1:0] hist, hist_next, mask;
  logic [CW-1:0]    seen, seen_next, need;
  logic             hit;

  // Comparison mask: the low SHORT_W bits always, the rest only in long mode.
  for (genvar i = 0; i < PAT_W; i++) begin : g_mask
    assign mask[i] = len_long || (i < SHORT_W);
  end

  assign hist_next = {hist[PAT_W-2:0], rx_bit};
  assign seen_next = (seen == CW'(PAT_W)) ? seen : seen + 1'b1;
  assign need      = len_long ? CW'(PAT_W) : CW'(SHORT_W);
  assign hit       = en && rx_strobe && rx_qual && (state == ST_HUNT)
                   && (seen_next >= need)
                   && (((hist_next ^ pattern) & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      hist  <= '0;
      seen  <= '0;
    end else if (!en) begin
      state <= ST_HUNT;
      hist  <= '0;
      seen  <= '0;
    end else if (state == ST_HUNT && rx_strobe) begin
      hist <= hist_next;
      seen <= seen_next;
      if (hit) state <= ST_CAPT;
    end
  end

  assign capturing = (state == ST_CAPT);
  assign push      = en && capturing && rx_strobe;

endmodule

// File: rtl/syncq_fifo.sv
module syncq_fifo
  import syncq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          din,
  input  logic          pop,
  output logic          head,
  output logic          avail,
  output logic [LW-1:0] level,
  output logic          ovf
);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    rd, wr;
  logic             pop_ok, push_ok;

  assign pop_ok  = pop && (level != '0);
  assign push_ok = push && ((level != LW'(DEPTH)) || pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd <= '0; wr <= '0; level <= '0; ovf <= 1'b0;
    end else if (flush) begin
      rd <= '0; wr <= '0; level <= '0; ovf <= 1'b0;
    end else begin
      if (push_ok) wr <= AW'(wrap_inc(int'(wr), DEPTH));
      if (pop_ok)  rd <= AW'(wrap_inc(int'(rd), DEPTH));
      level <= level + LW'(push_ok) - LW'(pop_ok);
      if (push && !push_ok) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr] <= din;
  end

  assign head  = mem[rd];
  assign avail = (level != '0);

endmodule

// File: rtl/syncq_spi_rd.sv
module syncq_spi_rd #(
  parameter int XFER_BITS = 16,
  localparam int XW       = $clog2(XFER_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_csn,
  input  logic head,
  input  logic avail,
  output logic pop,
  output logic sdo,
  output logic cs_active
);

  logic [1:0]    sck_sy, cs_sy;
  logic          sck_q, rise, fall, pending;
  logic [XW-1:0] pops;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= 2'b00;
      cs_sy  <= 2'b11;
      sck_q  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[0], spi_sck};
      cs_sy  <= {cs_sy[0], spi_csn};
      sck_q  <= sck_sy[1];
    end
  end

  assign cs_active = !cs_sy[1];
  assign rise      = sck_sy[1] && !sck_q;
  assign fall      = !sck_sy[1] && sck_q;

  // A rising edge arms one removal; the next falling edge performs it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      pops    <= '0;
    end else if (!cs_active) begin
      pending <= 1'b0;
      pops    <= '0;
    end else begin
      if (rise && pops < XW'(XFER_BITS)) pending <= 1'b1;
      if (fall && pending) begin
        pending <= 1'b0;
        pops    <= pops + 1'b1;
      end
    end
  end

  assign pop = cs_active && fall && pending;
  assign sdo = cs_active && avail && head;

endmodule

// File: rtl/syncq_rx.sv
module syncq_rx
  import syncq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int PAT_W    = 16,
  parameter int SHORT_W  = 8,
  localparam int LW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_strobe,
  input  logic             rx_qual,
  input  logic             cfg_en,
  input  logic [PAT_W-1:0] cfg_pattern,
  input  logic             cfg_len_long,
  input  logic [LW-1:0]    cfg_thresh,
  input  logic             spi_sck,
  input  logic             spi_csn,
  output logic             spi_sdo,
  output logic [LW-1:0]    fill_level,
  output logic             irq,
  output logic             ovf
);

  logic capturing, push, pop, head, avail, cs_active;

  syncq_hunter #(.PAT_W(PAT_W), .SHORT_W(SHORT_W)) u_hunt (
    .clk, .rst_n, .en(cfg_en), .rx_strobe, .rx_bit, .rx_qual,
    .pattern(cfg_pattern), .len_long(cfg_len_long),
    .capturing, .push
  );

  syncq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .flush(!cfg_en), .push, .din(rx_bit), .pop,
    .head, .avail, .level(fill_level), .ovf
  );

  syncq_spi_rd #(.XFER_BITS(DEPTH)) u_spi (
    .clk, .rst_n, .spi_sck, .spi_csn, .head, .avail,
    .pop, .sdo(spi_sdo), .cs_active
  );

  assign irq = int'(fill_level) >= clamp_thresh(int'(cfg_thresh), DEPTH);

endmodule

// File: rtl/syncq_rx_chk.sv
module syncq_rx_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          rx_strobe,
  input logic          rx_qual,
  input logic          capturing,
  input logic          cs_active,
  input logic          spi_sdo,
  input logic [LW-1:0] fill_level,
  input logic          irq,
  input logic          ovf
);

  p_level_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_level) <= DEPTH);

  p_level_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (int'(fill_level) + 1 >= int'($past(fill_level)))
               && (int'(fill_level) <= int'($past(fill_level)) + 1));

  p_hunt_no_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !capturing |=> int'(fill_level) <= int'($past(fill_level)));

  p_entry_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capturing) |-> $past(rx_qual && rx_strobe && cfg_en));

  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (fill_level == '0) && !ovf && !capturing);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cfg_en) |=> ovf);

  p_irq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0) |-> !irq);

  p_irq_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_level) == DEPTH) |-> irq);

  p_sdo_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !spi_sdo);

endmodule

bind syncq_rx syncq_rx_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .rx_strobe(rx_strobe),
  .rx_qual(rx_qual), .capturing(capturing), .cs_active(cs_active),
  .spi_sdo(spi_sdo), .fill_level(fill_level), .irq(irq), .ovf(ovf)
);

// File: tb/syncq_rx_bench.sv
`timescale 1ns/1ps
module syncq_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit = 1'b0, rx_strobe = 1'b0, rx_qual = 1'b0;
  logic        cfg_en = 1'b0, cfg_len_long = 1'b0;
  logic [15:0] cfg_pattern = 16'h0;
  logic [4:0]  cfg_thresh = 5'd1;
  logic        spi_sck = 1'b0, spi_csn = 1'b1;
  logic        spi_sdo, irq, ovf;
  logic [4:0]  fill_level;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  syncq_rx u_syncq_rx (
    .clk, .rst_n, .rx_bit, .rx_strobe, .rx_qual, .cfg_en, .cfg_pattern,
    .cfg_len_long, .cfg_thresh, .spi_sck, .spi_csn, .spi_sdo,
    .fill_level, .irq, .ovf
  );

  // ---------------- reference model ----------------
  logic [15:0] m_hist;
  int          m_seen;
  bit          m_cap, m_ovf;
  logic [15:0] mq;      // mq[0] is the oldest stored bit
  int          mqn;

  function automatic int exp_thr(input int t);
    if (t == 0) return 1;
    return (t > 16) ? 16 : t;
  endfunction

  function automatic bit word_match(input logic [15:0] h, input logic [15:0] p,
                                    input bit long_w);
    return long_w ? (h == p) : (h[7:0] == p[7:0]);
  endfunction

  task automatic model_clear();
    m_hist = '0; m_seen = 0; m_cap = 0; m_ovf = 0; mq = '0; mqn = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- stimulus tasks ----------------
  task automatic send_bit(input bit b, input bit q);
    @(negedge clk);
    rx_bit = b; rx_qual = q; rx_strobe = 1'b1;
    if (cfg_en) begin
      if (!m_cap) begin
        m_hist = {m_hist[14:0], b};
        if (m_seen < 16) m_seen++;
        if (q && m_seen >= (cfg_len_long ? 16 : 8) &&
            word_match(m_hist, cfg_pattern, cfg_len_long)) m_cap = 1;
      end else if (mqn < 16) begin
        mq[mqn] = b; mqn++;
      end else m_ovf = 1;
    end
    @(negedge clk);
    rx_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic arm(input logic [15:0] pat, input bit long_w, input int thr);
    @(negedge clk); cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    cfg_pattern = pat; cfg_len_long = long_w; cfg_thresh = 5'(thr);
    cfg_en = 1'b1;
    model_clear();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_status(input string req);
    repeat (2) @(negedge clk);
    chk({req, " level"}, int'(fill_level), mqn);
    chk({req, " ovf"},   int'(ovf), int'(m_ovf));
    chk("R7 irq", int'(irq), int'(mqn >= exp_thr(int'(cfg_thresh))));
  endtask

  // Clock n bits out; checks each bit against the model.
  task automatic spi_read(input int n, input string req);
    @(negedge clk); spi_csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      repeat (6) @(negedge clk);
      chk(req, int'(spi_sdo), (mqn > 0) ? int'(mq[0]) : 0);
      spi_sck = 1'b1;
      repeat (6) @(negedge clk);
      spi_sck = 1'b0;
      if (i < 16 && mqn > 0) begin
        mq = {1'b0, mq[15:1]}; mqn--;
      end
    end
    repeat (6) @(negedge clk);
    spi_csn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // prefix noise, sync word (MSB first), payload with random qual
  task automatic frame(input int pre_n, input bit qual_word, input int pay_n);
    int lw;
    lw = cfg_len_long ? 16 : 8;
    for (int i = 0; i < pre_n; i++) send_bit(1'($urandom), 1'($urandom % 4 != 0));
    for (int i = lw - 1; i >= 0; i--) send_bit(cfg_pattern[i], qual_word);
    for (int i = 0; i < pay_n; i++) send_bit(1'($urandom), 1'($urandom));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'h5EED_0042));
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 level", int'(fill_level), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 sdo", int'(spi_sdo), 0);

    // R2: disabled, pattern present with qual, nothing stored
    cfg_pattern = 16'h00B4; cfg_len_long = 1'b0;
    frame(3, 1'b1, 10);
    chk("R2 level", int'(fill_level), 0);

    // R3: qual low on whole stream, word never accepted
    arm(16'h002D, 1'b0, 4);
    for (int i = 7; i >= 0; i--) send_bit(cfg_pattern[i], 1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
    chk("R3 no capture", int'(fill_level), 0);

    // R4/R3: 8-bit word, 7 payload bits; word bits not stored
    arm(16'hFF96, 1'b0, 7);
    frame(0, 1'b1, 7);
    check_status("R3");
    spi_read(16, "R8 data");
    check_status("R10");

    // R4: long word with only low byte matching does not capture
    arm(16'hC396, 1'b1, 3);
    for (int i = 7; i >= 0; i--) send_bit(cfg_pattern[i], 1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b1);
    check_status("R4 partial");
    frame(2, 1'b1, 9);
    check_status("R4 long");
    spi_read(16, "R8 long data");

    // R6: overflow and full queue; R7 sweep; R9 partial reads
    arm(16'h3A5C, 1'b1, 16);
    frame(5, 1'b1, 21);
    check_status("R6");
    for (int t = 0; t < 21; t += 4) begin
      cfg_thresh = 5'(t);
      check_status("R7");
    end
    spi_read(5, "R9 partial");
    check_status("R9");
    for (int t = 9; t < 14; t++) begin
      cfg_thresh = 5'(t);
      check_status("R7");
    end
    spi_read(18, "R9 overlong");
    check_status("R9 rest");
    spi_read(4, "R8 empty");
    chk("R6 ovf sticky", int'(ovf), 1);

    // R5: re-arm flushes and clears overflow
    @(negedge clk); cfg_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 flush level", int'(fill_level), 0);
    chk("R5 flush ovf", int'(ovf), 0);

    // random frames
    for (int it = 0; it < 24; it++) begin
      arm(16'($urandom), 1'($urandom), int'($urandom % 20));
      frame(int'($urandom % 12), 1'($urandom % 4 != 0), int'($urandom % 20));
      check_status("R5");
      spi_read(int'($urandom % 17) + 1, "R8 random");
      check_status("R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule